// File: doc/BRIEF.md
# Word-Serial 192-bit Prime Field Adder/Subtractor

This block adds or subtracts two residues modulo the fixed prime p = 2^192 − 2^64 − 1. Both 192-bit operands and an operation select are captured on a start pulse. The block then processes the operands one word at a time, least significant word first, on a data path whose width is a parameter (8, 16, 32 or 64 bits). The result is ready after a fixed number of cycles and a one-cycle done flag marks that point.

Each job takes two passes over the words. The first pass forms the raw sum or difference and keeps the carry between words. The second pass takes that raw value and applies the reverse operation with p: it subtracts p after an addition and adds p after a subtraction. The carry flags from both passes decide which of the two candidate values is the reduced answer. A small state machine sequences the passes. Its done and busy outputs come from its state alone.

Top module: `fieldAddSubUnit`

## Requirements
- R1: When opSub = 0, the result after done equals (opA + opB) mod p for any operands below p. The sum is reduced by p exactly when opA + opB ≥ p, including the case where the sum overflows 192 bits.
- R2: When opSub = 1, the result after done equals (opA − opB) mod p. When opB > opA the result is opA − opB + p. Otherwise it is opA − opB.
- R3: The result shown while done is high is always below p.
- R4: A start sampled high at a rising edge while busy is low is accepted. done is high for exactly one cycle, beginning 2·(192/WORD_W) rising edges after the accepting edge.
- R5: A start raised while busy is high has no effect. The running job's result and done timing are unchanged, and its operands are not captured.
- R6: While reset is held and right after it, done = 0, busy = 0 and result = 0.
- R7: After done, result holds its value until the next accepted start, whatever opA, opB and opSub do in the meantime.
- R8: busy is high from the accepting edge through the done cycle, and low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a job; accepted only while idle |
| opSub | input | 1 | 0 = add, 1 = subtract; captured with start |
| opA | input | 192 | First operand, below p |
| opB | input | 192 | Second operand, below p |
| result | output | 192 | Reduced result, valid from done until the next accepted start |
| done | output | 1 | One-cycle completion flag |
| busy | output | 1 | High while a job is in progress |

## Verification
Suppose the word index or the inter-word carry goes wrong inside a pass. The damage shows up in result at the very next done pulse. It appears as one bad word, or as an off-by-p error when the reduce decision is wrong. Boundary operands make this visible: a sum equal to p, a sum with a carry out of bit 191, and a difference with opB > opA. A fault in the state machine's sequencing shows at the ports in a different way. done arrives early or late, lasts more than one cycle, or busy drops at the wrong time, and the bench measures all of these on every job. A start accepted while busy would show at the next done as a result computed from the wrong operands.

// File: rtl/fasPkg.sv
package fasPkg;
  localparam int FIELD_BITS = 192;
  localparam logic [FIELD_BITS-1:0] PRIME = ~(FIELD_BITS'(1) << 64);

  typedef struct packed {
    logic load;       // capture operands and operation
    logic runFirst;   // first pass: x = a, y = b
    logic runSecond;  // second pass: x = raw, y = prime
    logic firstWord;  // word index is zero: use initial carry
  } fasStrobe_t;
endpackage

// File: rtl/fasCtrl.sv
module fasCtrl
  import fasPkg::*;
#(
  parameter int NUM_WORDS = 6,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output fasStrobe_t       ctl,
  output logic [IDX_W-1:0] wordIdx,
  output logic             done,
  output logic             busy
);
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_FINISH = 2'd3
  } fasState_t;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  fasState_t state, stateNext;
  logic [IDX_W-1:0] idxNext;
  logic lastWord;

  assign lastWord = (wordIdx == LAST_IDX);

  always_comb begin
    stateNext = state;
    idxNext   = wordIdx;
    unique case (state)
      ST_IDLE: begin
        idxNext = '0;
        if (start) stateNext = ST_FIRST;
      end
      ST_FIRST: begin
        if (lastWord) begin
          stateNext = ST_SECOND;
          idxNext   = '0;
        end else begin
          idxNext = wordIdx + IDX_W'(1);
        end
      end
      ST_SECOND: begin
        if (lastWord) begin
          stateNext = ST_FINISH;
          idxNext   = '0;
        end else begin
          idxNext = wordIdx + IDX_W'(1);
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
    end else begin
      state   <= stateNext;
      wordIdx <= idxNext;
    end
  end

  always_comb begin
    ctl.load      = (state == ST_IDLE) && start;
    ctl.runFirst  = (state == ST_FIRST);
    ctl.runSecond = (state == ST_SECOND);
    ctl.firstWord = (wordIdx == '0);
  end

  assign done = (state == ST_FINISH);
  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/fasDatapath.sv
module fasDatapath
  import fasPkg::*;
#(
  parameter int WORD_W = 32,
  localparam int NUM_WORDS = FIELD_BITS / WORD_W,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fasStrobe_t            ctl,
  input  logic [IDX_W-1:0]      wordIdx,
  input  logic                  opSub,
  input  logic [FIELD_BITS-1:0] opA,
  input  logic [FIELD_BITS-1:0] opB,
  output logic [FIELD_BITS-1:0] result
);
  logic [WORD_W-1:0] aMem [NUM_WORDS];
  logic [WORD_W-1:0] bMem [NUM_WORDS];
  logic [WORD_W-1:0] rawMem [NUM_WORDS];   // first-pass value
  logic [WORD_W-1:0] adjMem [NUM_WORDS];   // second-pass value

  logic subReg;
  logic carry;
  logic firstCarry;

  logic [WORD_W-1:0] xWord, yWord, pWord, sumWord;
  logic invertY, carryIn, carryOut;
  logic useRaw;

  assign pWord   = PRIME[int'(wordIdx)*WORD_W +: WORD_W];
  assign xWord   = ctl.runSecond ? rawMem[wordIdx] : aMem[wordIdx];
  assign yWord   = ctl.runSecond ? pWord : bMem[wordIdx];
  assign invertY = ctl.runSecond ? ~subReg : subReg;
  assign carryIn = ctl.firstWord ? invertY : carry;
  assign {carryOut, sumWord} = {1'b0, xWord} + {1'b0, yWord ^ {WORD_W{invertY}}}
                               + (WORD_W+1)'(carryIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subReg     <= 1'b0;
      carry      <= 1'b0;
      firstCarry <= 1'b0;
      for (int i = 0; i < NUM_WORDS; i++) begin
        aMem[i]   <= '0;
        bMem[i]   <= '0;
        rawMem[i] <= '0;
        adjMem[i] <= '0;
      end
    end else begin
      if (ctl.load) begin
        subReg <= opSub;
        for (int i = 0; i < NUM_WORDS; i++) begin
          aMem[i] <= opA[i*WORD_W +: WORD_W];
          bMem[i] <= opB[i*WORD_W +: WORD_W];
        end
      end
      if (ctl.runFirst) begin
        rawMem[wordIdx] <= sumWord;
        carry           <= carryOut;
      end
      if (ctl.runSecond) begin
        adjMem[wordIdx] <= sumWord;
        carry           <= carryOut;
        if (ctl.firstWord) firstCarry <= carry;
      end
    end
  end

  // Add: raw kept when no overflow and raw - p borrowed.
  // Subtract: raw kept when first pass did not borrow.
  assign useRaw = subReg ? firstCarry : ~(firstCarry | carry);

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_resultWord
    assign result[g*WORD_W +: WORD_W] = useRaw ? rawMem[g] : adjMem[g];
  end
endmodule

// File: rtl/fieldAddSubUnit.sv
module fieldAddSubUnit
  import fasPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  opSub,
  input  logic [FIELD_BITS-1:0] opA,
  input  logic [FIELD_BITS-1:0] opB,
  output logic [FIELD_BITS-1:0] result,
  output logic                  done,
  output logic                  busy
);
  localparam int NUM_WORDS = FIELD_BITS / WORD_W;
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  fasStrobe_t       ctl;
  logic [IDX_W-1:0] wordIdx;

  fasCtrl #(.NUM_WORDS(NUM_WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .ctl(ctl), .wordIdx(wordIdx), .done(done), .busy(busy)
  );

  fasDatapath #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordIdx(wordIdx),
    .opSub(opSub), .opA(opA), .opB(opB), .result(result)
  );
endmodule

// File: rtl/fasChecker.sv
module fasChecker
  import fasPkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  start,
  input logic [FIELD_BITS-1:0] result,
  input logic                  done,
  input logic                  busy
);
  localparam int NUM_WORDS = FIELD_BITS / WORD_W;
  localparam int LATENCY   = 2 * NUM_WORDS;

  int unsigned cycCnt;
  always_ff @(posedge clk) begin
    if (!rstN) cycCnt <= 0;
    else if (!busy && start) cycCnt <= 0;
    else if (busy) cycCnt <= cycCnt + 1;
  end

  p_result_reduced_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result < PRIME));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_timing_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cycCnt == LATENCY));

  p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  p_no_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !done);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && !$past(start)) |-> $stable(result));
endmodule

bind fieldAddSubUnit fasChecker #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .result(result),
  .done(done), .busy(busy)
);

// File: tb/fieldAddSubUnit_tb_top.sv
module fieldAddSubUnit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = 192 / WORD_W;
  localparam int WAIT_EDGES = 2 * NUM_WORDS + 1; // falling edges from driving start to seeing done
  localparam logic [191:0] P = ~(192'(1) << 64);
  localparam int NVEC = 10;

  localparam logic [191:0] VEC_A [NVEC] = '{
    192'd0, P - 192'd5, P - 192'd1, 192'd1, P - 192'd1,
    192'd0, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, 192'd123456789, P - 192'd1, 192'd7};
  localparam logic [191:0] VEC_B [NVEC] = '{
    192'd0, 192'd5, P - 192'd1, 192'd2, P - 192'd1,
    P - 192'd1, 192'd1, 192'd123456789, 192'd1, 192'd7};
  localparam logic VEC_S [NVEC] = '{
    1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
    1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic opSub = 1'b0;
  logic [191:0] opA = '0, opB = '0;
  logic [191:0] result;
  logic done, busy;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fieldAddSubUnit #(.WORD_W(WORD_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opSub(opSub),
    .opA(opA), .opB(opB), .result(result), .done(done), .busy(busy)
  );

  function automatic logic [191:0] refModOp(logic [191:0] a, logic [191:0] b, logic sub);
    logic [193:0] s;
    if (!sub) begin
      s = {2'b0, a} + {2'b0, b};
      if (s >= {2'b0, P}) s = s - {2'b0, P};
    end else begin
      if (a >= b) s = {2'b0, a} - {2'b0, b};
      else        s = {2'b0, a} + {2'b0, P} - {2'b0, b};
    end
    return s[191:0];
  endfunction

  function automatic logic [191:0] randBelowP();
    logic [191:0] v;
    for (int i = 0; i < 6; i++) v[i*32 +: 32] = $urandom;
    if (v >= P) v = v - P;
    return v;
  endfunction

  task automatic checkVal(string req, logic [191:0] act, logic [191:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Run one job; optional second start while busy with other operands (R5).
  task automatic runJob(logic [191:0] a, logic [191:0] b, logic sub,
                        string req, bit pokeBusy);
    int edges;
    logic [191:0] exp;
    exp = refModOp(a, b, sub);
    @(negedge clk);
    opA = a; opB = b; opSub = sub; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    checkVal("R8 busy after accept", 192'(busy), 192'd1);
    if (pokeBusy) begin
      opA = randBelowP(); opB = randBelowP(); opSub = ~sub; start = 1'b1;
    end
    while (!done && edges < 1000) begin
      @(negedge clk);
      start = 1'b0;
      edges++;
      if (!done) begin
        nChecks++;
        if (busy !== 1'b1) begin
          nFails++;
          $display("FAIL R8: busy %b expected 1 before done", busy);
        end
      end
    end
    checkVal({req, " R4 latency"}, 192'(edges), 192'(WAIT_EDGES));
    checkVal({req, " result"}, result, exp);
    nChecks++;
    if (result >= P) begin
      nFails++;
      $display("FAIL R3: result %h expected below %h", result, P);
    end
    @(negedge clk);
    checkVal("R4 done one cycle", 192'(done), 192'd0);
    checkVal("R8 idle after done", 192'(busy), 192'd0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : main
    logic [191:0] held;
    repeat (3) @(negedge clk);
    // R6 reset state
    checkVal("R6 done in reset", 192'(done), 192'd0);
    checkVal("R6 busy in reset", 192'(busy), 192'd0);
    checkVal("R6 result in reset", result, 192'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R6 done after reset", 192'(done), 192'd0);
    checkVal("R6 result after reset", result, 192'd0);

    // Table of boundary vectors: R1 for add, R2 for subtract
    for (int i = 0; i < NVEC; i++)
      runJob(VEC_A[i], VEC_B[i], VEC_S[i], VEC_S[i] ? "R2 table" : "R1 table", 1'b0);

    // Random operands below p
    for (int i = 0; i < 30; i++)
      runJob(randBelowP(), randBelowP(), 1'b0, "R1 random", 1'b0);
    for (int i = 0; i < 30; i++)
      runJob(randBelowP(), randBelowP(), 1'b1, "R2 random", 1'b0);

    // R5: start while busy is ignored
    runJob(P - 192'd3, 192'd9, 1'b0, "R5 add poke", 1'b1);
    runJob(192'd4, 192'd11, 1'b1, "R5 sub poke", 1'b1);

    // R7: result holds while inputs change and no start
    held = result;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      opA = randBelowP(); opB = randBelowP(); opSub = ~opSub;
    end
    checkVal("R7 hold", result, held);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule